// File: doc/BRIEF.md
# Signed Array Multiply-Accumulate Unit

This block multiplies a signed 8-bit sample by a signed 8-bit coefficient and adds the 16-bit result into an accumulator register. The product comes from an explicit grid of cells rather than a behavioural multiply operator. Each cell ANDs one sample bit with one coefficient bit. It then adds that term to the sum and carry of the same weight that the row above produced.

Signed operands are handled inside the array by weighting the sign terms, not by sign-extending the operands. The partial-product terms that pair exactly one sign bit with a non-sign bit are complemented. Two constant ones are added at weights 2^8 and 2^15. A ripple-carry row merges the last row's sums and carries into the upper product half. A second ripple-carry adder adds the product into the accumulator.

The operand pair is taken on every clock edge where the accumulate enable is high. The unit has no back-pressure. It accepts one pair per cycle without stalling, so no ready signal is needed. The enable plays the part of a valid qualifier. The product is also driven out combinationally, which lets the array be observed on its own.

Top module: `smac_unit`

## Requirements
- R1: `prod` equals the two's-complement product of `sample` and `coeff`, both read as signed 8-bit values, as a 16-bit two's-complement value, within the same cycle, for every one of the 65,536 operand pairs.
- R2: The corner products are exact: -128 x -128 gives 0x4000, -128 x 127 gives 0xC080 (-16256), and 0 x -128 gives 0x0000.
- R3: While `rst_n` is low, `acc` is 0x0000.
- R4: On a rising edge with `clr` high, `acc` becomes 0x0000, whatever the value of `acc_en`.
- R5: On a rising edge with `clr` low and `acc_en` high, `acc` becomes its previous value plus `prod`, taken modulo 2^16. Consecutive enabled cycles each add their own product, with no stall.
- R6: On a rising edge with both `clr` and `acc_en` low, `acc` keeps its value, whatever `sample` and `coeff` carry.
- R7: An overflow of the accumulator wraps modulo 2^16 without saturating. Two additions of 0x4000 to zero give 0x8000, and two more give 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Loads zero into the accumulator; has priority over acc_en |
| acc_en | input | 1 | Adds the current product into the accumulator on this edge |
| sample | input | 8 | Signed multiplicand |
| coeff | input | 8 | Signed multiplier |
| prod | output | 16 | Combinational signed product |
| acc | output | 16 | Accumulator register |

## Verification
The immediate checks on the array and on the ripple adders assume only that the operands are known values, since every bit pattern is a legal two's-complement number. The stimulus therefore sweeps all operand pairs and never leaves an input undriven once reset is released. The clocked properties on the accumulator assume that `clr` and `acc_en` are stable around each rising edge. The bench changes every input only on the falling edge, half a cycle away from the edge that samples it.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int OP_W  = 8;
  localparam int ACC_W = 16;
  localparam int PROD_W = 2 * OP_W;
endpackage

// File: rtl/smac_cell.sv
// One array cell: partial-product bit (optionally negative-weighted by
// complement) plus, for full-adder cells, the sum and carry of equal weight.
module smac_cell #(
  parameter bit NEG_W  = 1'b0,
  parameter bit ADDER  = 1'b1
) (
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);
  logic term;

  always_comb begin
    term = NEG_W ? ~(a_bit & b_bit) : (a_bit & b_bit);
  end

  generate
    if (ADDER) begin : g_fa
      always_comb begin
        sum_out   = term ^ sum_in ^ carry_in;
        carry_out = (term & sum_in) | (term & carry_in) | (sum_in & carry_in);
      end
      always_comb begin
        assert_cell_sum_R1: assert ({carry_out, sum_out} ==
          2'(term) + 2'(sum_in) + 2'(carry_in))
          else $error("cell adder mismatch");
      end
    end else begin : g_edge
      always_comb begin
        sum_out   = term;
        carry_out = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/smac_ripple.sv
// Ripple-carry adder, bit-serial carry chain.
module smac_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int EXT_W = W + 1;

  always_comb begin
    logic cy;
    cy = cin;
    for (int k = 0; k < W; k++) begin
      sum[k] = x[k] ^ y[k] ^ cy;
      cy     = (x[k] & y[k]) | (x[k] & cy) | (y[k] & cy);
    end
    cout = cy;
  end

  always_comb begin
    assert_ripple_sum_R5: assert ({cout, sum} ==
      EXT_W'(x) + EXT_W'(y) + EXT_W'(cin))
      else $error("ripple adder mismatch");
  end
endmodule

// File: rtl/smac_array.sv
// Signed array multiplier: rows of cells in carry-save form, sign terms
// complemented, constant ones at weights OP_W and 2*OP_W-1, ripple final row.
module smac_array #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int PW = 2 * N;

  generate
    for (genvar i = 0; i < N; i++) begin : g_row
      logic [N-1:0] s_row;
      logic [N-1:0] c_row;
      for (genvar j = 0; j < N; j++) begin : g_col
        localparam bit NEG = ((i == N-1) != (j == N-1));
        logic s_in;
        logic c_in;
        if (i == 0) begin : g_top
          assign s_in = 1'b0;
          assign c_in = 1'b0;
        end else begin : g_body
          if (j < N-1) begin : g_inner
            assign s_in = g_row[i-1].s_row[j+1];
          end else if (i == 1) begin : g_const
            assign s_in = 1'b1;   // constant one at weight N
          end else begin : g_zero
            assign s_in = 1'b0;
          end
          assign c_in = g_row[i-1].c_row[j];
        end
        smac_cell #(
          .NEG_W (NEG),
          .ADDER (i != 0)
        ) u_cell (
          .a_bit     (a[j]),
          .b_bit     (b[i]),
          .sum_in    (s_in),
          .carry_in  (c_in),
          .sum_out   (s_row[j]),
          .carry_out (c_row[j])
        );
      end
      assign p[i] = s_row[0];
    end
  endgenerate

  logic [N-1:0] fin_x;
  logic         fin_cout;

  generate
    for (genvar k = 0; k < N; k++) begin : g_fin
      if (k < N-1) begin : g_s
        assign fin_x[k] = g_row[N-1].s_row[k+1];
      end else begin : g_top1
        assign fin_x[k] = 1'b1;   // constant one at weight 2N-1
      end
    end
  endgenerate

  smac_ripple #(.W(N)) u_final (
    .x    (fin_x),
    .y    (g_row[N-1].c_row),
    .cin  (1'b0),
    .sum  (p[PW-1:N]),
    .cout (fin_cout)
  );

  always_comb begin
    assert_array_prod_R1: assert ($signed(p) ==
      PW'($signed(a) * $signed(b)))
      else $error("array product mismatch");
  end
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int N   = OP_W,
  parameter int AW  = ACC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            acc_en,
  input  logic [N-1:0]    sample,
  input  logic [N-1:0]    coeff,
  output logic [2*N-1:0]  prod,
  output logic [AW-1:0]   acc
);
  localparam int PW = 2 * N;

  logic [AW-1:0] prod_ext;
  logic [AW-1:0] acc_next;
  logic          acc_cout;

  smac_array #(.N(N)) u_array (
    .a (sample),
    .b (coeff),
    .p (prod)
  );

  generate
    if (AW > PW) begin : g_sext
      assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[AW-1:0];
    end
  endgenerate

  smac_ripple #(.W(AW)) u_acc_add (
    .x    (acc),
    .y    (prod_ext),
    .cin  (1'b0),
    .sum  (acc_next),
    .cout (acc_cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (acc_en) acc <= acc_next;
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !acc_en) |=> $stable(acc));

  assert_accum_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && acc_en) |=> (acc == AW'($past(acc) + $past(prod_ext))));
endmodule

// File: tb/smac_unit_tb_top.sv
module smac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        acc_en = 1'b0;
  logic [7:0]  sample = '0;
  logic [7:0]  coeff = '0;
  logic [15:0] prod;
  logic [15:0] acc;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] model = '0;

  always #2 clk = ~clk;   // 250 MHz

  smac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
    .sample(sample), .coeff(coeff), .prod(prod), .acc(acc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle at the falling edge and queues the expected acc
  task automatic drive(input logic c, input logic e, input int a, input int b, input string req);
    int p;
    @(negedge clk);
    clr = c; acc_en = e; sample = a[7:0]; coeff = b[7:0];
    p = $signed(a[7:0]) * $signed(b[7:0]);
    if (c)      model = '0;
    else if (e) model = model + p[15:0];
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  // monitor: compares acc just after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), acc, exp_q.pop_front());
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p;
    #5;
    check("R3", acc, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R1: exhaustive product sweep, accumulator idle
    for (int ai = -128; ai < 128; ai++) begin
      for (int bi = -128; bi < 128; bi++) begin
        @(negedge clk);
        sample = ai[7:0]; coeff = bi[7:0];
        #1;
        p = ai * bi;
        check("R1", prod, p[15:0]);
      end
    end

    // R2: corner products
    @(negedge clk); sample = 8'h80; coeff = 8'h80; #1; check("R2", prod, 16'h4000);
    @(negedge clk); sample = 8'h80; coeff = 8'h7F; #1; check("R2", prod, 16'hC080);
    @(negedge clk); sample = 8'h00; coeff = 8'h80; #1; check("R2", prod, 16'h0000);

    // R6: idle hold during the sweep left acc at zero
    check("R6", acc, 16'h0000);

    // R5: back-to-back accumulation
    drive(1, 0, 0, 0, "R4");
    drive(0, 1, 3, 5, "R5");
    drive(0, 1, -7, 9, "R5");
    drive(0, 1, 127, -128, "R5");
    // R6: hold with busy operands
    drive(0, 0, 100, 100, "R6");
    drive(0, 0, -100, 55, "R6");
    // R4: clear beats enable
    drive(1, 1, 127, 127, "R4");
    // R7: wrap without saturation
    drive(0, 1, -128, -128, "R7");
    drive(0, 1, -128, -128, "R7");
    drive(0, 1, -128, -128, "R7");
    drive(0, 1, -128, -128, "R7");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 15);
      drive(r == 0, r > 3, $urandom_range(0, 255), $urandom_range(0, 255),
            (r == 0) ? "R4" : (r > 3) ? "R5" : "R6");
    end

    drive(0, 0, 0, 0, "R6");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule